// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where the operand of a 16-bit instruction lives. From a 3-bit addressing-mode code and a 3-bit register number, it looks at the contents of eight 32-bit address registers and, when needed, a 16-bit extension word. It reports the 24-bit bus address of the operand, a flag saying whether the operand is in memory or in a register, and a flag for mode codes it does not support.

The block only computes the address. It writes no register and never touches memory. The instruction sequencer reads the combinational outputs in the same cycle, or reads the registered copy one clock later.

In the displacement mode, the extension word is sign-extended to the full register width and added to the whole 32-bit register value. Only the low 24 bits of the sum reach the address output, so any carry out of bit 23 is dropped.

Top module: `ea_gen`

## Requirements
- R1: With mode code 3'b010, the address output equals bits 23:0 of the address register chosen by the register number.
- R2: With mode code 3'b101, the 16-bit extension word is sign-extended to 32 bits and added to the chosen 32-bit address register. The address output is bits 23:0 of that sum.
- R3: A negative displacement behaves as two's complement. For example, extension 16'hFFFC with register value 32'h00000008 gives address 24'h000004.
- R4: With mode codes 3'b000 or 3'b001, the memory flag is 0, the illegal flag is 0 and the address output is 0.
- R5: With mode codes 3'b010 or 3'b101, the memory flag is 1 and the illegal flag is 0.
- R6: With mode codes 3'b011, 3'b100, 3'b110 or 3'b111, the illegal flag is 1, the memory flag is 0 and the address output is 0.
- R7: The extension word has no effect on any output unless the mode code is 3'b101.
- R8: Only the address register chosen by the register number affects the address. The other seven have no effect.
- R9: The registered outputs hold, one clock later, the values the combinational outputs had before that rising edge.
- R10: While synchronous reset is high at a rising edge, all registered outputs become 0.
- R11: A carry out of bit 23 is discarded. For example, register 32'h00FFFFFE plus extension 16'h0004 gives 24'h000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing mode code |
| regnum_i | input | 3 | Register number |
| areg_bus_i | input | 256 | Address registers, register k at bits 32k+31:32k |
| ext_word_i | input | 16 | Extension (displacement) word |
| ea_o | output | 24 | Combinational effective address |
| is_mem_o | output | 1 | Operand is in memory |
| illegal_o | output | 1 | Unsupported mode code |
| ea_q_o | output | 24 | Registered effective address |
| is_mem_q_o | output | 1 | Registered memory flag |
| illegal_q_o | output | 1 | Registered illegal flag |

## Verification
The bench targets negative displacements and sums that carry past bit 23. A design that zero-extends the displacement, or that adds only 24 bits after sign extension in the wrong place, returns an address off by 64K or with a stray high bit. It sweeps all eight mode codes, so a design that reads modes 3, 4, 6 or 7 as legal, or that flags modes 0 and 1 as memory, is caught on the flags. It changes the extension word in mode 2 and the unselected registers in every mode, so a design that decodes the mode or register number wrongly shows a moved address. It also checks that the registered copy lags by exactly one clock.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_REG_W  = 32;
    localparam int EA_ADDR_W = 24;
    localparam int EA_DISP_W = 16;
    localparam int EA_NREGS  = 8;

    typedef enum logic [2:0] {
        EA_DATA_DIRECT = 3'b000,
        EA_ADDR_DIRECT = 3'b001,
        EA_INDIRECT    = 3'b010,
        EA_IND_DISP    = 3'b101
    } ea_mode_e;

    typedef struct packed {
        logic is_mem;
        logic use_disp;
        logic illegal;
    } ea_class_t;

    function automatic ea_class_t classify_mode(input logic [2:0] code);
        ea_class_t c;
        c = '0;
        case (code)
            EA_DATA_DIRECT, EA_ADDR_DIRECT: c = '0;
            EA_INDIRECT:  begin c.is_mem = 1'b1; end
            EA_IND_DISP:  begin c.is_mem = 1'b1; c.use_disp = 1'b1; end
            default:      begin c.illegal = 1'b1; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [2:0] mode_i,
    output ea_class_t  cls_o
);
    always_comb begin
        cls_o = classify_mode(mode_i);
    end
endmodule

// File: rtl/ea_reg_mux.sv
module ea_reg_mux #(
    parameter int NREGS = 8,
    parameter int REG_W = 32,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic [NREGS*REG_W-1:0] bus_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic [REG_W-1:0]       reg_o
);
    logic [REG_W-1:0] regs [NREGS];

    for (genvar k = 0; k < NREGS; k++) begin : g_unpack
        assign regs[k] = bus_i[k*REG_W +: REG_W];
    end

    always_comb begin
        reg_o = regs[sel_i];
    end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int ADDR_W = 24,
    parameter int DISP_W = 16
) (
    input  ea_class_t          cls_i,
    input  logic [REG_W-1:0]   base_i,
    input  logic [DISP_W-1:0]  disp_i,
    output logic [ADDR_W-1:0]  ea_o
);
    localparam int EXT_W = REG_W - DISP_W;

    logic [REG_W-1:0] disp_ext;
    logic [REG_W-1:0] offset;
    logic [REG_W-1:0] sum;

    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        offset   = cls_i.use_disp ? disp_ext : '0;
        sum      = base_i + offset;
        ea_o     = cls_i.is_mem ? sum[ADDR_W-1:0] : '0;
    end
endmodule

// File: rtl/ea_out_reg.sv
module ea_out_reg #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic              is_mem_i,
    input  logic              illegal_i,
    output logic [ADDR_W-1:0] ea_q,
    output logic              is_mem_q,
    output logic              illegal_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q      <= '0;
            is_mem_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            ea_q      <= ea_i;
            is_mem_q  <= is_mem_i;
            illegal_q <= illegal_i;
        end
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int NREGS  = EA_NREGS,
    parameter int REG_W  = EA_REG_W,
    parameter int ADDR_W = EA_ADDR_W,
    parameter int DISP_W = EA_DISP_W,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             mode_i,
    input  logic [SEL_W-1:0]       regnum_i,
    input  logic [NREGS*REG_W-1:0] areg_bus_i,
    input  logic [DISP_W-1:0]      ext_word_i,
    output logic [ADDR_W-1:0]      ea_o,
    output logic                   is_mem_o,
    output logic                   illegal_o,
    output logic [ADDR_W-1:0]      ea_q_o,
    output logic                   is_mem_q_o,
    output logic                   illegal_q_o
);
    ea_class_t        cls;
    logic [REG_W-1:0] base;

    ea_mode_dec u_dec (
        .mode_i (mode_i),
        .cls_o  (cls)
    );

    ea_reg_mux #(.NREGS(NREGS), .REG_W(REG_W)) u_mux (
        .bus_i (areg_bus_i),
        .sel_i (regnum_i),
        .reg_o (base)
    );

    ea_addr_calc #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
        .cls_i  (cls),
        .base_i (base),
        .disp_i (ext_word_i),
        .ea_o   (ea_o)
    );

    assign is_mem_o  = cls.is_mem;
    assign illegal_o = cls.illegal;

    ea_out_reg #(.ADDR_W(ADDR_W)) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .ea_i      (ea_o),
        .is_mem_i  (is_mem_o),
        .illegal_i (illegal_o),
        .ea_q      (ea_q_o),
        .is_mem_q  (is_mem_q_o),
        .illegal_q (illegal_q_o)
    );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int NREGS  = 8,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 24,
    parameter int DISP_W = 16,
    localparam int SEL_W = $clog2(NREGS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             mode_i,
    input logic [SEL_W-1:0]       regnum_i,
    input logic [NREGS*REG_W-1:0] areg_bus_i,
    input logic [DISP_W-1:0]      ext_word_i,
    input logic [ADDR_W-1:0]      ea_o,
    input logic                   is_mem_o,
    input logic                   illegal_o,
    input logic [ADDR_W-1:0]      ea_q_o,
    input logic                   is_mem_q_o,
    input logic                   illegal_q_o
);
    logic [REG_W-1:0] picked;
    assign picked = areg_bus_i[regnum_i*REG_W +: REG_W];

    // R1
    indirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'b010) |-> (ea_o == picked[ADDR_W-1:0]));

    // R4
    direct_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'b000 || mode_i == 3'b001) |-> (!is_mem_o && !illegal_o && ea_o == '0));

    // R5
    mem_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 3'b010 || mode_i == 3'b101) |-> (is_mem_o && !illegal_o));

    // R6
    illegal_excl_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!is_mem_o && ea_o == '0));

    // R9
    lag_one_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ea_q_o == $past(ea_o) && is_mem_q_o == $past(is_mem_o)
                  && illegal_q_o == $past(illegal_o)));

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({is_mem_o, illegal_o}));
endmodule

bind ea_gen ea_gen_chk #(
    .NREGS(NREGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)
) u_chk (.*);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
    localparam int NR = 8;
    localparam int RW = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        mode = '0;
    logic [2:0]        rnum = '0;
    logic [NR*RW-1:0]  regs = '0;
    logic [15:0]       ext = '0;
    logic [23:0]       ea, ea_q;
    logic              is_mem, illegal, is_mem_q, illegal_q;

    int checks = 0;
    int errors = 0;
    logic [23:0] prev_ea = '0;
    logic        prev_mem = 1'b0;
    logic        prev_ill = 1'b0;
    logic        have_prev = 1'b0;

    always #10 clk = ~clk;

    ea_gen u_dut (
        .clk(clk), .rst(rst), .mode_i(mode), .regnum_i(rnum),
        .areg_bus_i(regs), .ext_word_i(ext),
        .ea_o(ea), .is_mem_o(is_mem), .illegal_o(illegal),
        .ea_q_o(ea_q), .is_mem_q_o(is_mem_q), .illegal_q_o(illegal_q)
    );

    function automatic logic exp_mem(input logic [2:0] m);
        return (m == 3'b010) || (m == 3'b101);
    endfunction

    function automatic logic exp_ill(input logic [2:0] m);
        return !(m == 3'b000 || m == 3'b001 || m == 3'b010 || m == 3'b101);
    endfunction

    function automatic logic [23:0] exp_ea(input logic [2:0] m, input logic [2:0] r,
                                           input logic [NR*RW-1:0] b, input logic [15:0] d);
        logic [31:0] base, sum;
        base = b[r*RW +: RW];
        if (m == 3'b010) return base[23:0];
        if (m == 3'b101) begin
            sum = base + {{16{d[15]}}, d};
            return sum[23:0];
        end
        return 24'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [2:0] m, input logic [2:0] r,
                         input logic [NR*RW-1:0] b, input logic [15:0] d);
        @(negedge clk);
        if (have_prev) begin
            check("R9 ea_q", {8'h0, ea_q}, {8'h0, prev_ea});
            check("R9 flags", {30'h0, is_mem_q, illegal_q}, {30'h0, prev_mem, prev_ill});
        end
        mode = m; rnum = r; regs = b; ext = d;
        #1;
        check(req, {8'h0, ea}, {8'h0, exp_ea(m, r, b, d)});
        check(req, {30'h0, is_mem, illegal}, {30'h0, exp_mem(m), exp_ill(m)});
        prev_ea = exp_ea(m, r, b, d);
        prev_mem = exp_mem(m);
        prev_ill = exp_ill(m);
        have_prev = 1'b1;
    endtask

    function automatic logic [NR*RW-1:0] rand_regs();
        logic [NR*RW-1:0] v;
        for (int k = 0; k < NR; k++) v[k*RW +: RW] = $urandom;
        return v;
    endfunction

    initial begin
        logic [NR*RW-1:0] b;
        logic [23:0] ref_ea;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: registered outputs cleared by reset
        check("R10", {6'h0, ea_q, is_mem_q, illegal_q}, 32'h0);
        rst = 1'b0;

        // R3 negative displacement
        b = rand_regs(); b[0 +: RW] = 32'h0000_0008;
        apply("R3", 3'b101, 3'd0, b, 16'hFFFC);
        check("R3 value", {8'h0, ea}, 32'h0000_0004);
        // R11 carry past bit 23 dropped
        b[3*RW +: RW] = 32'h00FF_FFFE;
        apply("R11", 3'b101, 3'd3, b, 16'h0004);
        check("R11 value", {8'h0, ea}, 32'h0000_0002);
        // R2 positive displacement, upper register bits matter only through carry
        b[5*RW +: RW] = 32'hD3AB_0073;
        apply("R2", 3'b101, 3'd5, b, 16'h7FFF);
        check("R2 value", {8'h0, ea}, 32'h00AB_8072);
        // R1 indirect
        apply("R1", 3'b010, 3'd5, b, 16'h1234);
        ref_ea = ea;
        // R7 extension ignored in mode 2
        apply("R7", 3'b010, 3'd5, b, 16'h8000);
        check("R7 unchanged", {8'h0, ea}, {8'h0, ref_ea});
        // R8 other registers ignored
        for (int k = 0; k < NR; k++) if (k != 5) b[k*RW +: RW] = ~b[k*RW +: RW];
        apply("R8", 3'b010, 3'd5, b, 16'h0);
        check("R8 unchanged", {8'h0, ea}, {8'h0, ref_ea});
        // R4 / R5 / R6 sweep of every mode code
        for (int m = 0; m < 8; m++) begin
            apply(m < 2 ? "R4" : (exp_ill(3'(m)) ? "R6" : "R5"), 3'(m), 3'(m), rand_regs(), 16'(m * 4099));
        end
        // R7 extension ignored in direct and illegal modes
        apply("R7 direct", 3'b000, 3'd1, b, 16'hFFFF);
        apply("R7 illegal", 3'b111, 3'd1, b, 16'hFFFF);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            apply("R2 rand", 3'($urandom), 3'($urandom), rand_regs(), 16'($urandom));
        end

        // R10 reset mid-run
        @(negedge clk);
        mode = 3'b010; rst = 1'b1;
        @(negedge clk);
        check("R10 mid", {6'h0, ea_q, is_mem_q, illegal_q}, 32'h0);
        rst = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule